// File: doc/BRIEF.md
# Parallel Flash Command Sequencer

This block decodes the write side of a NOR flash device model that uses the two-cycle unlock command protocol. Each bus write strobe carries a byte address and a data word. The sequencer scales the byte address to a word address for 8-, 16- or 32-bit devices. It checks the unlock cycles against two configurable 11-bit unlock addresses and steps through the command protocol. It reports the current protocol state on a mode output.

Program data cycles produce a one-cycle request to the storage array. That request carries the AND of the written word and the word currently stored, so programming can only clear bits. Chip and sector erase commands produce one-cycle erase requests. While an erase runs, a separate erase controller owns the timing. It signals completion on `erase_done`, and until then the sequencer ignores bus writes. An unlock-bypass mode lets software issue commands with no unlock pair and no address check.

Top module: `flash_cmd_seq`

## Requirements
- R1: The `mode` output uses these codes: 0 read, 1 first unlock seen, 2 command cycle, 3 erase setup, 4 erase unlock seen, 5 erase command cycle, 6 program data pending, 7 autoselect, 8 CFI query, 9 CFI query entered from autoselect, 10 chip erase running, 11 sector erase running. After reset, `mode` is 0, `bypass` is 0 and no request is active.
- R2: The byte address is shifted right by 0, 1 or 2 for a DATA_W of 8, 16 or 32. Only the low 11 bits of the resulting word address are compared, so higher address bits and the dropped byte-lane bits do not affect the unlock matches.
- R3: From read, writing 0xAA (data bits 7:0) at unlock address 0 moves to mode 1. In mode 1, writing 0x55 at unlock address 1 moves to mode 2. Any other write in either of these cycles returns to mode 0.
- R4: Outside bypass, a command cycle at an address other than unlock address 0 returns to mode 0. At unlock address 0, the codes are 0x80 to mode 3, 0x90 to mode 7, 0xA0 to mode 6 and 0x20 to bypass. Any other code returns to mode 0.
- R5: After 0x80, a second 0xAA/0x55 unlock pair leads to mode 5. There, 0x10 at unlock address 0 pulses `chip_erase_req` and enters mode 10. 0x30 at any address pulses `sect_erase_req`, places that byte address on `erase_addr` and enters mode 11. Any other write returns to mode 0.
- R6: In mode 6, the next write pulses `prog_req` for exactly one cycle. The pulse carries `prog_addr` equal to the written byte address and `prog_data` equal to the written data ANDed with `rd_data`. The mode then returns to 0, or to 2 when in bypass.
- R7: Data 0xF0 returns the sequencer to mode 0 in every mode except 6, 10 and 11. In mode 9 it returns to mode 7 instead. In mode 6, 0xF0 is treated as program data.
- R8: Writing 0x98 at word address 0x55 enters mode 8 from read (or erase setup) and mode 9 from autoselect. In modes 8 and 9, any write other than 0xF0 returns to mode 0.
- R9: A command code of 0x20 sets `bypass` and returns to mode 2. In bypass, the command cycle accepts any address. A completed program returns to mode 2, and writing 0x00 in autoselect returns to mode 0.
- R10: In modes 10 and 11, every bus write is ignored. A pulse on `erase_done` leaves the erase mode for mode 0, or for mode 2 when `bypass` is set.
- R11: Every path that returns to mode 0 also clears `bypass`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data; bits 7:0 carry the command code |
| rd_data | input | DATA_W | Current array word at `wr_addr`, from storage |
| erase_done | input | 1 | Erase controller completion pulse |
| mode | output | 4 | Protocol state code (see R1) |
| bypass | output | 1 | Unlock-bypass active |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | ADDR_W | Byte address to program |
| prog_data | output | DATA_W | Word to store (AND of old and new) |
| chip_erase_req | output | 1 | One-cycle chip erase request |
| sect_erase_req | output | 1 | One-cycle sector erase request |
| erase_addr | output | ADDR_W | Byte address inside the sector to erase |

## Verification
Every result is registered once. A write presented before clock edge N shows its new `mode` and `bypass` values, and any request pulse, in the cycle that follows edge N. The request pulses fall at edge N+1. The bench drives each write at a falling edge, holds it across one rising edge and samples at the next falling edge, exactly one register stage later. Pulse width is checked one further falling edge on. An `erase_done` pulse is timed the same way.

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20,
  parameter logic [10:0] UNLOCK_A0 = 11'h555,
  parameter logic [10:0] UNLOCK_A1 = 11'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              erase_done,
  output logic [3:0]        mode,
  output logic              bypass,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [DATA_W-1:0] prog_data,
  output logic              chip_erase_req,
  output logic              sect_erase_req,
  output logic [ADDR_W-1:0] erase_addr
);
  localparam int SHIFT = (DATA_W == 32) ? 2 : (DATA_W == 16) ? 1 : 0;
  localparam logic [3:0] M_READ = 4'd0, M_UNLK = 4'd1, M_CMD = 4'd2,
    M_ESET = 4'd3, M_EUNLK = 4'd4, M_ECMD = 4'd5, M_PROG = 4'd6,
    M_AUTO = 4'd7, M_CFI = 4'd8, M_CFI_AS = 4'd9, M_CHIP = 4'd10,
    M_SECT = 4'd11;

  logic [ADDR_W-1:0] word_addr;
  logic [10:0]       wa;
  logic [7:0]        code;
  logic              at_a0, at_a1, at_q, busy;
  logic [3:0]        nxt_mode;
  logic              nxt_byp, nxt_prog, nxt_chip, nxt_sect;

  assign word_addr = wr_addr >> SHIFT;
  assign wa    = word_addr[10:0];
  assign code  = wr_data[7:0];
  assign at_a0 = (wa == UNLOCK_A0);
  assign at_a1 = (wa == UNLOCK_A1);
  assign at_q  = (wa == 11'h055) && (code == 8'h98);
  assign busy  = (mode == M_CHIP) || (mode == M_SECT);

  always_comb begin
    nxt_mode = mode;
    nxt_byp  = bypass;
    nxt_prog = 1'b0;
    nxt_chip = 1'b0;
    nxt_sect = 1'b0;
    if (busy) begin
      if (erase_done) nxt_mode = bypass ? M_CMD : M_READ;
    end else if (wr_en) begin
      if (code == 8'hF0 && mode != M_PROG) begin
        nxt_mode = (mode == M_CFI_AS) ? M_AUTO : M_READ;
      end else begin
        nxt_mode = M_READ;
        case (mode)
          M_READ, M_ESET: begin
            if (at_q) nxt_mode = M_CFI;
            else if (at_a0 && code == 8'hAA) nxt_mode = (mode == M_READ) ? M_UNLK : M_EUNLK;
          end
          M_UNLK:  if (at_a1 && code == 8'h55) nxt_mode = M_CMD;
          M_EUNLK: if (at_a1 && code == 8'h55) nxt_mode = M_ECMD;
          M_CMD: begin
            if (bypass || at_a0) begin
              case (code)
                8'h20: begin nxt_byp = 1'b1; nxt_mode = M_CMD; end
                8'h80: nxt_mode = M_ESET;
                8'h90: nxt_mode = M_AUTO;
                8'hA0: nxt_mode = M_PROG;
                default: nxt_mode = M_READ;
              endcase
            end
          end
          M_ECMD: begin
            if (code == 8'h10 && at_a0) begin
              nxt_mode = M_CHIP;
              nxt_chip = 1'b1;
            end else if (code == 8'h30) begin
              nxt_mode = M_SECT;
              nxt_sect = 1'b1;
            end
          end
          M_PROG: begin
            nxt_prog = 1'b1;
            nxt_mode = bypass ? M_CMD : M_READ;
          end
          M_AUTO: if (!(bypass && code == 8'h00) && at_q) nxt_mode = M_CFI_AS;
          default: nxt_mode = M_READ;
        endcase
      end
    end
    if (nxt_mode == M_READ) nxt_byp = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode           <= M_READ;
      bypass         <= 1'b0;
      prog_req       <= 1'b0;
      prog_addr      <= '0;
      prog_data      <= '0;
      chip_erase_req <= 1'b0;
      sect_erase_req <= 1'b0;
      erase_addr     <= '0;
    end else begin
      mode           <= nxt_mode;
      bypass         <= nxt_byp;
      prog_req       <= nxt_prog;
      chip_erase_req <= nxt_chip;
      sect_erase_req <= nxt_sect;
      if (nxt_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data & rd_data;
      end
      if (nxt_chip || nxt_sect) erase_addr <= wr_addr;
    end
  end
endmodule

// File: rtl/flash_cmd_seq_chk.sv
module flash_cmd_seq_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              erase_done,
  input logic [3:0]        mode,
  input logic              bypass,
  input logic              prog_req,
  input logic [DATA_W-1:0] prog_data,
  input logic              chip_erase_req,
  input logic              sect_erase_req
);
  a_r1_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_req, chip_erase_req, sect_erase_req}));

  a_r6_prog_from_pending: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> ($past(mode) == 4'd6 && $past(wr_en)));

  a_r6_only_clears_bits: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |-> (((prog_data | $past(wr_data)) == $past(wr_data)) &&
                  ((prog_data | $past(rd_data)) == $past(rd_data))));

  a_r5_chip_from_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase_req |-> ($past(mode) == 4'd5 && mode == 4'd10));

  a_r10_erase_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 4'd10 || mode == 4'd11) && !erase_done) |=> $stable(mode));

  a_r11_read_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 4'd0) |-> !bypass);

  a_r9_bypass_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass) |-> ($past(mode) == 4'd2 && $past(wr_data[7:0]) == 8'h20));
endmodule

bind flash_cmd_seq flash_cmd_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .erase_done(erase_done), .mode(mode), .bypass(bypass), .prog_req(prog_req),
  .prog_data(prog_data), .chip_erase_req(chip_erase_req),
  .sect_erase_req(sect_erase_req)
);

// File: tb/tb_flash_cmd_seq.sv
module tb_flash_cmd_seq;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 20;
  localparam logic [ADDR_W-1:0] A0B = 20'h555 << 1;
  localparam logic [ADDR_W-1:0] A1B = 20'h2AA << 1;
  localparam logic [ADDR_W-1:0] QB  = 20'h055 << 1;

  logic clk = 0, rst_n = 0, wr_en = 0, erase_done = 0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0, rd_data;
  logic [3:0] mode;
  logic bypass, prog_req, chip_erase_req, sect_erase_req;
  logic [ADDR_W-1:0] prog_addr, erase_addr;
  logic [DATA_W-1:0] prog_data;
  logic [DATA_W-1:0] mem [0:255];
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  flash_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_data(rd_data), .erase_done(erase_done), .mode(mode), .bypass(bypass),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .chip_erase_req(chip_erase_req), .sect_erase_req(sect_erase_req),
    .erase_addr(erase_addr)
  );

  assign rd_data = mem[wr_addr[8:1]];
  always @(posedge clk) if (prog_req) mem[prog_addr[8:1]] <= prog_data;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic unlock;
    wr(A0B, 16'h00AA);
    wr(A1B, 16'h0055);
  endtask

  task automatic done_pulse;
    @(negedge clk);
    erase_done = 1;
    @(negedge clk);
    erase_done = 0;
  endtask

  task automatic t_reset;
    check("R1 mode", mode, 0);
    check("R1 bypass", bypass, 0);
    check("R1 reqs", {prog_req, chip_erase_req, sect_erase_req}, 0);
  endtask

  task automatic t_unlock;
    wr(A0B, 16'h00AA); check("R3 first", mode, 1);
    wr(20'h100, 16'h0055); check("R3 bad addr", mode, 0);
    wr(A0B, 16'h00AB); check("R3 bad data", mode, 0);
    wr(A0B, 16'h00AA); wr(A1B, 16'h0056); check("R3 bad second", mode, 0);
    wr(A0B, 16'h00AA); wr(A1B, 16'h0055); check("R3 done", mode, 2);
    wr(A0B, 16'h0077); check("R4 bad code", mode, 0);
    wr(A0B, 16'h00AA); wr(A1B, 16'h00F0); check("R7 F0 in unlock", mode, 0);
  endtask

  task automatic t_alias;
    wr(A0B | 20'h01001, 16'h00AA); check("R2 alias", mode, 1);
    wr(A1B | 20'h80000, 16'h0055); check("R2 alias second", mode, 2);
    wr(A1B, 16'h00A0); check("R4 cmd wrong addr", mode, 0);
  endtask

  task automatic t_program;
    mem[8] = 16'h33FF;
    unlock; wr(A0B, 16'h00A0); check("R4 program", mode, 6);
    wr(20'h10, 16'h0F0F);
    check("R6 req", prog_req, 1);
    check("R6 addr", prog_addr, 20'h10);
    check("R6 data", prog_data, 16'h030F);
    check("R6 mode", mode, 0);
    @(negedge clk); check("R6 one cycle", prog_req, 0);
    unlock; wr(A0B, 16'h00A0); wr(20'h12, 16'h00F0);
    check("R7 F0 as data", prog_req, 1);
    check("R7 F0 data", prog_data, 16'h00F0);
  endtask

  task automatic t_cfi;
    unlock; wr(A0B, 16'h0090); check("R4 autoselect", mode, 7);
    wr(QB, 16'h0098); check("R8 cfi from auto", mode, 9);
    wr(20'h0, 16'h00F0); check("R7 back to auto", mode, 7);
    wr(QB, 16'h0098); wr(20'h4, 16'h0012); check("R8 write resets", mode, 0);
    wr(QB, 16'h0098); check("R8 cfi from read", mode, 8);
    wr(20'h0, 16'h00F0); check("R7 cfi to read", mode, 0);
  endtask

  task automatic t_erase;
    unlock; wr(A0B, 16'h0080); check("R5 setup", mode, 3);
    unlock; check("R5 erase cmd", mode, 5);
    wr(A0B, 16'h0010);
    check("R5 chip req", chip_erase_req, 1); check("R5 chip mode", mode, 10);
    wr(A0B, 16'h00F0); check("R10 F0 ignored", mode, 10);
    check("R10 req dropped", chip_erase_req, 0);
    done_pulse; check("R10 done", mode, 0);
    unlock; wr(A0B, 16'h0080); unlock; wr(20'h4000, 16'h0030);
    check("R5 sect req", sect_erase_req, 1);
    check("R5 sect addr", erase_addr, 20'h4000);
    wr(A0B, 16'h00AA); check("R10 write ignored", mode, 11);
    done_pulse; check("R10 sect done", mode, 0);
    unlock; wr(A0B, 16'h0080); unlock; wr(A1B, 16'h0010);
    check("R5 chip wrong addr", mode, 0);
    check("R5 no chip req", chip_erase_req, 0);
  endtask

  task automatic t_bypass;
    unlock; wr(A0B, 16'h0020);
    check("R9 bypass set", bypass, 1); check("R9 cmd mode", mode, 2);
    wr(20'h0, 16'h00A0); check("R9 program no unlock", mode, 6);
    wr(20'h12, 16'hA5A5);
    check("R9 prog data", prog_data, 16'h00A0);
    check("R9 return cmd", mode, 2); check("R9 still bypass", bypass, 1);
    wr(20'h0, 16'h0090); check("R9 autoselect", mode, 7);
    wr(20'h0, 16'h0000); check("R9 exit", mode, 0); check("R11 exit clears", bypass, 0);
    unlock; wr(A0B, 16'h0020); wr(20'h0, 16'h00F0);
    check("R11 F0 clears", bypass, 0);
    unlock; wr(A0B, 16'h0020); wr(20'h0, 16'h0080); unlock; wr(20'h2000, 16'h0030);
    check("R9 bypass sect", mode, 11);
    done_pulse; check("R10 done bypass", mode, 2); check("R10 keep bypass", bypass, 1);
    wr(20'h0, 16'h0077); check("R11 bad code clears", bypass, 0); check("R4 bad code", mode, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_unlock;
    t_alias;
    t_program;
    t_cfi;
    t_erase;
    t_bypass;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule